// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block decides which of three system power states the board is in: S0 (running), S3 (suspend to memory) or S5 (soft off). It makes that decision from two active-low sleep requests and a set of supply-good flags. From the current state it then orders the enables of three regulators. The first is a main memory rail. The second is a termination tracker that follows half of the main rail. The third is a core rail for the memory controller. Analog behaviour is modelled only through flags: the main rail's in-regulation report is an input, and the ramp times are cycle counters.

On the way up from S5, the main rail soft-starts on its own first. The tracker and the core rail start only after two things hold: the main rail's soft-start window has run out, and the main rail reports in regulation. The core rail's window is shorter, half of the main one by default.

In S3 the main rail stays alive in a standby mode, the tracker output floats, and the core rail's gates are held low. Returning from S3 to S0 restarts only the core rail and the tracker. A fault input forces every control to its off values for as long as it stays high.

Top module: `pwr_state_seq`

## Requirements
- R1: While reset is held and right after it, `pwr_state` reads S5 (encoding S0=0, S3=1, S5=2). All enables and soft-start flags are low, `term_hiz` is high and both gate-off outputs are high.
- R2: `boot_mon_en` is high only when both `ref_good` and `sup5_good` are high. While either one is low, the state is S5, and it moves to S5 on the next clock from any state.
- R3: From S5 the state moves to S0 one clock after `sleep3_n`, `sleep5_n` and `sup12_good` are all high. If any of the three is low, it stays in S5.
- R4: In S0, a low `sleep5_n` moves the state to S5. This takes priority over `sleep3_n`. Otherwise a low `sleep3_n` moves the state to S3.
- R5: In S3, a low `sleep5_n` moves the state to S5. Otherwise a high `sleep3_n` moves the state to S0 if `sup12_good` is high and to S5 if it is low.
- R6: In S3 with `sleep3_n` low and `sleep5_n` high, losing `sup12_good` leaves the state in S3 and the main rail enabled.
- R7: On entry to S0 from S5, `main_en` rises and `main_ss` is high for exactly MAIN_SS_CYC consecutive cycles. During that window the core rail and the tracker stay off.
- R8: The core rail and the tracker turn on only after the main soft-start window has ended and `main_in_reg` is high. `core_ss` rises on the clock after `main_in_reg` is seen and stays high for exactly CORE_SS_CYC cycles. After that, `core_en` and `term_en` remain high.
- R9: In S3, `main_en` and `main_stby` are high, `core_en` and `term_en` are low, and `core_gate_off` and `term_hiz` are high.
- R10: On a return from S3 to S0, `main_ss` never rises. Once `main_in_reg` is high, the core rail runs a fresh CORE_SS_CYC soft-start and the tracker turns back on.
- R11: In S5, every enable is low, both gate-off outputs are high and `term_hiz` is high.
- R12: While `fault` is high, in the same cycle, all enables and soft-start flags are low, both gate-off outputs and `term_hiz` are high, and the state is left unchanged. After `fault` falls in S0, the main rail runs a full soft-start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_good | input | 1 | Internal reference is settled |
| sup5_good | input | 1 | Standby 5 V supply is within limits |
| sup12_good | input | 1 | 12 V gate-drive supply is within limits |
| sleep3_n | input | 1 | Active-low request for S3 |
| sleep5_n | input | 1 | Active-low request for S5 |
| main_in_reg | input | 1 | Main rail reports in regulation |
| fault | input | 1 | Latched fault, forces everything off |
| pwr_state | output | 2 | Decoded state: 0=S0, 1=S3, 2=S5 |
| boot_mon_en | output | 1 | Enable for the 12 V supply monitor |
| main_en | output | 1 | Main rail enable |
| main_ss | output | 1 | Main rail soft-start window active |
| main_stby | output | 1 | Main rail in standby (doubled switching rate) |
| main_gate_off | output | 1 | Force both main rail gates low |
| core_en | output | 1 | Core rail enable |
| core_ss | output | 1 | Core rail soft-start window active |
| core_gate_off | output | 1 | Force both core rail gates low |
| term_en | output | 1 | Termination tracker enable |
| term_hiz | output | 1 | Termination output high-impedance |

## Verification
A state register that decodes the wrong power state shows up at `pwr_state` one clock after the sleep inputs change. At the same moment it shows up as a wrong combination of `main_stby`, `core_gate_off` and `term_hiz`, because those outputs are decoded from the state directly. A wrong sequencing phase appears one clock later. It is visible as a soft-start window that opens when it should not, as a window whose length differs from the parameter, or as a core or tracker enable that comes on before `main_in_reg`. Measuring each window length and the delay to `core_ss` reveals a timer off by one within a single soft-start interval.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Decoded power state. The encoding is visible on the pwr_state port.
  typedef enum logic [1:0] {
    PSS_S0 = 2'd0,
    PSS_S3 = 2'd1,
    PSS_S5 = 2'd2
  } pss_state_e;

  // Rail sequencing phase.
  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_MAIN_SS = 3'd1,
    PH_MAIN_RG = 3'd2,
    PH_CORE_SS = 3'd3,
    PH_RUN     = 3'd4,
    PH_STBY    = 3'd5
  } pss_phase_e;

  localparam int unsigned RAIL_MAIN = 0;
  localparam int unsigned RAIL_CORE = 1;
  localparam int unsigned NUM_SS    = 2;

  // Controls driven to the regulators.
  typedef struct packed {
    logic main_en;
    logic main_ss;
    logic main_stby;
    logic core_en;
    logic core_ss;
    logic term_en;
  } pss_ctl_t;

endpackage

// File: rtl/pss_state_fsm.sv
module pss_state_fsm
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_good,
  input  logic       sup5_good,
  input  logic       sup12_good,
  input  logic       sleep3_n,
  input  logic       sleep5_n,
  output pss_state_e state_q,
  output logic       boot_mon_en
);

  pss_state_e state_d;
  logic       base_ok;
  logic       hv_ok;

  // The 12 V monitor is armed only once the reference and the 5 V rail are good.
  assign base_ok     = ref_good & sup5_good;
  assign boot_mon_en = base_ok;
  assign hv_ok       = base_ok & sup12_good;

  always_comb begin
    state_d = state_q;
    if (!base_ok) begin
      state_d = PSS_S5;
    end else begin
      unique case (state_q)
        PSS_S5: begin
          if (sleep3_n && sleep5_n && hv_ok) state_d = PSS_S0;
        end
        PSS_S0: begin
          if (!sleep5_n)      state_d = PSS_S5;
          else if (!sleep3_n) state_d = PSS_S3;
        end
        PSS_S3: begin
          if (!sleep5_n)     state_d = PSS_S5;
          else if (sleep3_n) state_d = hv_ok ? PSS_S0 : PSS_S5;
          // sleep3_n low: hold S3 whatever the 12 V supply does
        end
        default: state_d = PSS_S5;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PSS_S5;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pss_ss_timer.sv
module pss_ss_timer #(
  parameter int unsigned CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW   = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = run && (cnt_q == LAST);
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pss_rail_seq.sv
module pss_rail_seq
  import pss_pkg::*;
#(
  parameter int unsigned MAIN_SS_CYC = 1000,
  parameter int unsigned CORE_SS_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pss_state_e state_q,
  input  logic       main_in_reg,
  input  logic       fault,
  output pss_phase_e phase_q
);

  pss_phase_e        phase_d;
  logic [NUM_SS-1:0] ss_run;
  logic [NUM_SS-1:0] ss_done;
  logic              in_s0;

  assign in_s0 = (state_q == PSS_S0) && !fault;

  assign ss_run[RAIL_MAIN] = in_s0 && (phase_q == PH_MAIN_SS);
  assign ss_run[RAIL_CORE] = in_s0 && (phase_q == PH_CORE_SS);

  for (genvar r = 0; r < NUM_SS; r++) begin : g_ss
    localparam int unsigned CYC = (r == RAIL_MAIN) ? MAIN_SS_CYC : CORE_SS_CYC;
    pss_ss_timer #(.CYC(CYC)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ss_run[r]),
      .done (ss_done[r])
    );
  end

  always_comb begin
    phase_d = phase_q;
    if (fault) begin
      phase_d = PH_OFF;
    end else begin
      unique case (state_q)
        PSS_S5: phase_d = PH_OFF;
        PSS_S3: phase_d = (phase_q == PH_OFF) ? PH_OFF : PH_STBY;
        PSS_S0: begin
          unique case (phase_q)
            PH_OFF:     phase_d = PH_MAIN_SS;
            PH_STBY:    phase_d = PH_MAIN_RG;
            PH_MAIN_SS: if (ss_done[RAIL_MAIN]) phase_d = PH_MAIN_RG;
            PH_MAIN_RG: if (main_in_reg)        phase_d = PH_CORE_SS;
            PH_CORE_SS: if (ss_done[RAIL_CORE]) phase_d = PH_RUN;
            PH_RUN:     phase_d = PH_RUN;
            default:    phase_d = PH_OFF;
          endcase
        end
        default: phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_OFF;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/pss_out_map.sv
module pss_out_map
  import pss_pkg::*;
(
  input  pss_state_e state_q,
  input  pss_phase_e phase_q,
  input  logic       fault,
  output pss_ctl_t   ctl
);

  logic live;
  logic in_s0;
  logic in_s3;
  logic core_up;

  assign live    = !fault;
  assign in_s0   = live && (state_q == PSS_S0);
  assign in_s3   = live && (state_q == PSS_S3);
  assign core_up = (phase_q == PH_CORE_SS) || (phase_q == PH_RUN);

  always_comb begin
    ctl           = '0;
    ctl.main_en   = (in_s0 || in_s3) && (phase_q != PH_OFF);
    ctl.main_ss   = in_s0 && (phase_q == PH_MAIN_SS);
    ctl.main_stby = in_s3 && (phase_q != PH_OFF);
    ctl.core_en   = in_s0 && core_up;
    ctl.core_ss   = in_s0 && (phase_q == PH_CORE_SS);
    ctl.term_en   = in_s0 && core_up;
  end

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int unsigned MAIN_SS_CYC = 1000,
  parameter int unsigned CORE_SS_CYC = MAIN_SS_CYC / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_good,
  input  logic       sup5_good,
  input  logic       sup12_good,
  input  logic       sleep3_n,
  input  logic       sleep5_n,
  input  logic       main_in_reg,
  input  logic       fault,
  output logic [1:0] pwr_state,
  output logic       boot_mon_en,
  output logic       main_en,
  output logic       main_ss,
  output logic       main_stby,
  output logic       main_gate_off,
  output logic       core_en,
  output logic       core_ss,
  output logic       core_gate_off,
  output logic       term_en,
  output logic       term_hiz
);

  pss_state_e state_q;
  pss_phase_e phase_q;
  pss_ctl_t   ctl;

  pss_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_good   (ref_good),
    .sup5_good  (sup5_good),
    .sup12_good (sup12_good),
    .sleep3_n   (sleep3_n),
    .sleep5_n   (sleep5_n),
    .state_q    (state_q),
    .boot_mon_en(boot_mon_en)
  );

  pss_rail_seq #(
    .MAIN_SS_CYC(MAIN_SS_CYC),
    .CORE_SS_CYC(CORE_SS_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .main_in_reg(main_in_reg),
    .fault      (fault),
    .phase_q    (phase_q)
  );

  pss_out_map u_map (
    .state_q(state_q),
    .phase_q(phase_q),
    .fault  (fault),
    .ctl    (ctl)
  );

  assign pwr_state     = state_q;
  assign main_en       = ctl.main_en;
  assign main_ss       = ctl.main_ss;
  assign main_stby     = ctl.main_stby;
  assign main_gate_off = !ctl.main_en;
  assign core_en       = ctl.core_en;
  assign core_ss       = ctl.core_ss;
  assign core_gate_off = !ctl.core_en;
  assign term_en       = ctl.term_en;
  assign term_hiz      = !ctl.term_en;

endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_good,
  input logic       sup5_good,
  input logic       sup12_good,
  input logic       sleep3_n,
  input logic       sleep5_n,
  input logic       main_in_reg,
  input logic       fault,
  input logic [1:0] pwr_state,
  input logic       boot_mon_en,
  input logic       main_en,
  input logic       main_stby,
  input logic       core_en,
  input logic       core_ss,
  input logic       term_en,
  input logic       term_hiz
);

  // R2
  base_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_good && sup5_good) |=> pwr_state == 2'd2);

  // R3
  s5_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && !(sleep3_n && sleep5_n && sup12_good)) |=> pwr_state != 2'd0);

  // R6
  s3_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 && !sleep3_n && sleep5_n && ref_good && sup5_good) |=> pwr_state == 2'd1);

  // R8
  core_after_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ss) |-> $past(main_in_reg));

  // R9
  stby_only_s3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_stby |-> (pwr_state == 2'd1 && !core_en && term_hiz));

  // R11
  s5_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |-> (!main_en && !core_en && !term_en));

  // R12
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!main_en && !core_en && !term_en && term_hiz));

  // R2
  mon_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_mon_en |-> (ref_good && sup5_good));

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_good   (ref_good),
  .sup5_good  (sup5_good),
  .sup12_good (sup12_good),
  .sleep3_n   (sleep3_n),
  .sleep5_n   (sleep5_n),
  .main_in_reg(main_in_reg),
  .fault      (fault),
  .pwr_state  (pwr_state),
  .boot_mon_en(boot_mon_en),
  .main_en    (main_en),
  .main_stby  (main_stby),
  .core_en    (core_en),
  .core_ss    (core_ss),
  .term_en    (term_en),
  .term_hiz   (term_hiz)
);

// File: tb/pwr_state_seq_test.sv
module pwr_state_seq_test;

  localparam int MAIN_CYC = 20;
  localparam int CORE_CYC = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_good, sup5_good, sup12_good, sleep3_n, sleep5_n, main_in_reg, fault;
  logic [1:0] pwr_state;
  logic boot_mon_en, main_en, main_ss, main_stby, main_gate_off;
  logic core_en, core_ss, core_gate_off, term_en, term_hiz;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwr_state_seq #(.MAIN_SS_CYC(MAIN_CYC), .CORE_SS_CYC(CORE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ref_good(ref_good), .sup5_good(sup5_good),
    .sup12_good(sup12_good), .sleep3_n(sleep3_n), .sleep5_n(sleep5_n),
    .main_in_reg(main_in_reg), .fault(fault), .pwr_state(pwr_state),
    .boot_mon_en(boot_mon_en), .main_en(main_en), .main_ss(main_ss),
    .main_stby(main_stby), .main_gate_off(main_gate_off), .core_en(core_en),
    .core_ss(core_ss), .core_gate_off(core_gate_off), .term_en(term_en),
    .term_hiz(term_hiz)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Wait (at negedges) until sig is high; returns cycles waited or -1.
  task automatic wait_main_ss(output int waited);
    waited = -1;
    for (int i = 0; i < 200; i++) begin
      if (main_ss) begin waited = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_core_ss(output int waited, output int saw_main_ss);
    waited = -1;
    saw_main_ss = 0;
    for (int i = 0; i < 200; i++) begin
      if (main_ss) saw_main_ss = 1;
      if (core_ss) begin waited = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure_main_ss(output int len);
    len = 0;
    while (main_ss && len < 500) begin
      if (core_en || term_en) chk("R7", "core/term on in main window", 1, 0);
      len++;
      @(negedge clk);
    end
  endtask

  task automatic measure_core_ss(output int len);
    len = 0;
    while (core_ss && len < 500) begin len++; @(negedge clk); end
  endtask

  task automatic s5_outputs(input string req);
    chk(req, "main_en", int'(main_en), 0);
    chk(req, "core_en", int'(core_en), 0);
    chk(req, "term_hiz", int'(term_hiz), 1);
    chk(req, "main_gate_off", int'(main_gate_off), 1);
    chk(req, "core_gate_off", int'(core_gate_off), 1);
  endtask

  task automatic bring_up_run();
    int w;
    int len;
    sleep3_n = 1; sleep5_n = 1; sup12_good = 1; main_in_reg = 1; fault = 0;
    wait_main_ss(w);
    measure_main_ss(len);
    w = 0;
    while (!(core_en && !core_ss) && w < 200) begin w++; @(negedge clk); end
  endtask

  task automatic t_reset();
    rst_n = 0; ref_good = 1; sup5_good = 1; sup12_good = 1;
    sleep3_n = 1; sleep5_n = 1; main_in_reg = 0; fault = 0;
    tick(3);
    chk("R1", "pwr_state in reset", int'(pwr_state), 2);
    s5_outputs("R1");
    chk("R1", "main_ss", int'(main_ss), 0);
    rst_n = 1;
  endtask

  task automatic t_power_up();
    int w;
    int len;
    chk("R3", "state after release", int'(pwr_state), 2);
    tick(1);
    chk("R3", "S5 to S0", int'(pwr_state), 0);
    wait_main_ss(w);
    chk("R7", "main_en with main_ss", int'(main_en), 1);
    measure_main_ss(len);
    chk("R7", "main soft-start length", len, MAIN_CYC);
    tick(5);
    chk("R8", "core off without in_reg", int'(core_en), 0);
    chk("R8", "term_hiz without in_reg", int'(term_hiz), 1);
    main_in_reg = 1;
    tick(1);
    chk("R8", "core_ss one clock after in_reg", int'(core_ss), 1);
    measure_core_ss(len);
    chk("R8", "core soft-start length", len, CORE_CYC);
    chk("R8", "core_en after window", int'(core_en), 1);
    chk("R8", "term_en after window", int'(term_en), 1);
  endtask

  task automatic t_s3_cycle();
    int w;
    int saw;
    int len;
    sleep3_n = 0;
    tick(1);
    chk("R4", "S0 to S3", int'(pwr_state), 1);
    chk("R9", "main_en", int'(main_en), 1);
    chk("R9", "main_stby", int'(main_stby), 1);
    chk("R9", "core_en", int'(core_en), 0);
    chk("R9", "core_gate_off", int'(core_gate_off), 1);
    chk("R9", "term_hiz", int'(term_hiz), 1);
    sup12_good = 0;
    tick(4);
    chk("R6", "S3 held on 12V loss", int'(pwr_state), 1);
    chk("R6", "main_en held", int'(main_en), 1);
    sup12_good = 1;
    tick(1);
    sleep3_n = 1;
    tick(1);
    chk("R5", "S3 to S0", int'(pwr_state), 0);
    wait_core_ss(w, saw);
    chk("R10", "main_ss never rises", saw, 0);
    chk("R10", "core_ss restarted", int'(core_ss), 1);
    measure_core_ss(len);
    chk("R10", "core restart length", len, CORE_CYC);
    chk("R10", "term_en back", int'(term_en), 1);
  endtask

  task automatic t_s3_exit_to_s5();
    sleep3_n = 0;
    tick(2);
    sup12_good = 0;
    tick(1);
    sleep3_n = 1;
    tick(1);
    chk("R5", "S3 high sleep3 no 12V to S5", int'(pwr_state), 2);
    s5_outputs("R11");
    tick(3);
    chk("R3", "S5 held without 12V", int'(pwr_state), 2);
    sup12_good = 1; sleep5_n = 0;
    tick(3);
    chk("R3", "S5 held with sleep5_n low", int'(pwr_state), 2);
    sleep5_n = 1;
    bring_up_run();
    sleep3_n = 0;
    tick(2);
    chk("R4", "in S3 before sleep5", int'(pwr_state), 1);
    sleep5_n = 0;
    tick(1);
    chk("R5", "S3 sleep5_n low to S5", int'(pwr_state), 2);
  endtask

  task automatic t_s0_priority();
    sleep5_n = 1; sleep3_n = 1;
    bring_up_run();
    chk("R4", "in S0 run", int'(core_en), 1);
    sleep3_n = 0; sleep5_n = 0;
    tick(1);
    chk("R4", "sleep5 priority to S5", int'(pwr_state), 2);
    s5_outputs("R11");
  endtask

  task automatic t_supply_gate();
    sleep3_n = 1; sleep5_n = 1;
    bring_up_run();
    sup5_good = 0;
    #1;
    chk("R2", "boot_mon_en low", int'(boot_mon_en), 0);
    tick(1);
    chk("R2", "S0 to S5 on 5V loss", int'(pwr_state), 2);
    ref_good = 0; sup5_good = 1;
    tick(4);
    chk("R2", "S5 held without ref", int'(pwr_state), 2);
    chk("R2", "boot_mon_en without ref", int'(boot_mon_en), 0);
    ref_good = 1;
    #1;
    chk("R2", "boot_mon_en armed", int'(boot_mon_en), 1);
  endtask

  task automatic t_fault();
    int w;
    int len;
    bring_up_run();
    fault = 1;
    #1;
    chk("R12", "main_en under fault", int'(main_en), 0);
    chk("R12", "core_en under fault", int'(core_en), 0);
    chk("R12", "term_hiz under fault", int'(term_hiz), 1);
    chk("R12", "gates off under fault", int'(main_gate_off & core_gate_off), 1);
    tick(3);
    chk("R12", "state unchanged", int'(pwr_state), 0);
    chk("R12", "main_ss held off", int'(main_ss), 0);
    fault = 0;
    wait_main_ss(w);
    chk("R12", "main_ss after release", int'(main_ss), 1);
    measure_main_ss(len);
    chk("R12", "restart length", len, MAIN_CYC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_power_up();
    t_s3_cycle();
    t_s3_exit_to_s5();
    t_s0_priority();
    t_supply_gate();
    t_fault();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule